// File: doc/BRIEF.md
# Serial-Load Multichannel DAC Register Interface

This block is the digital front end of a six-channel, 10-bit converter. A host shifts a 14-bit word in over a serial clock and data line. The word carries a 4-bit channel number and a 10-bit code. A level-sensitive load line then copies that word into the output register of the addressed channel. An active-low clear line forces every channel register to zero. It leaves the shift register as it was.

All four serial-side lines are asynchronous to the block. Each one passes through a two-flop synchronizer clocked by a faster system clock. Serial clock edges are found by comparing the present and the previous synchronized samples.

Load is transparent. While it is high, every shift goes straight through to a channel register. The serial clock is not meant to move while load is high. When it does, the block still performs the pass-through, and it also sets a sticky violation flag.

The data path has no power-on value. Channel registers and the shift register are undefined until the first clear or load. The system reset `rst` only initialises the synchronizers, the edge detector and the flag.

Top module: `sdac_front`

## Requirements
- R1: The frame is 14 bits, shifted most significant bit first, one bit on each rising serial clock edge. After the last shift, bits 13:10 hold the channel number and bits 9:0 hold the code.
- R2: While load is high and clear is inactive, channel number k (1 to 6) writes the shifted code into channel k. Channel k appears on `ch_out[10k-1:10(k-1)]`. All other channels keep their values.
- R3: Channel numbers 0 and 7 to 15 change no channel register.
- R4: Driving `ser_rst_n` low sets all six channel registers to zero within a few system cycles.
- R5: The clear line does not alter the shift register. A load that follows a clear, with no new shifts, restores the word that was shifted in before the clear.
- R6: Clear has priority over load. While `ser_rst_n` is low, the channel registers stay at zero even when load is high.
- R7: The serial clock level at the moment load rises does not matter. A load during which the serial clock stays still writes normally and does not set the violation flag.
- R8: Any serial clock edge while load is high passes each newly shifted word through to the addressed channel register. It also sets `viol`.
- R9: `viol` is cleared by `rst` and by `ser_rst_n` going low. Otherwise, once set, it stays set through later normal loads.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System oversampling clock |
| rst | input | 1 | Synchronous active-high system reset (synchronizers, edge detector, flag) |
| ser_clk | input | 1 | Asynchronous serial shift clock |
| ser_dat | input | 1 | Asynchronous serial data |
| ser_ld | input | 1 | Asynchronous level-sensitive load |
| ser_rst_n | input | 1 | Asynchronous active-low clear of all channel registers |
| ch_out | output | 60 | Six 10-bit channel registers, channel 1 in the low bits |
| viol | output | 1 | Sticky flag: serial clock moved while load was high |

## Verification
The assertions check the cycle-level rules on every cycle:
- clear forces zero on the following cycle;
- a valid channel number with load high writes the code;
- an invalid channel number with load high leaves every register still;
- the shift register moves only on a detected rising edge;
- the flag sets on an edge under load, and it stays set or stays clear as required.

The directed scenarios are needed for the end-to-end behaviours:
- bit ordering through the synchronizers;
- a word surviving a clear and coming back on the next load;
- load rising while the serial clock is high;
- the full chain of intermediate words written during a pass-through.

// File: rtl/sdac_pkg.sv
package sdac_pkg;
  localparam int DEF_DATA_W = 10;
  localparam int DEF_ADDR_W = 4;
  localparam int DEF_NUM_CH = 6;
  localparam int DEF_SYNC   = 2;
endpackage

// File: rtl/sdac_sync.sv
module sdac_sync #(
  parameter int          WIDTH   = 4,
  parameter int          STAGES  = 2,
  parameter logic [WIDTH-1:0] RST_VAL = '0
) (
  input  logic             clk,
  input  logic             rst,
  input  logic [WIDTH-1:0] d,
  output logic [WIDTH-1:0] q
);
  logic [WIDTH-1:0] st [STAGES];

  always_ff @(posedge clk) begin
    if (rst) begin
      for (int i = 0; i < STAGES; i++) st[i] <= RST_VAL;
    end else begin
      st[0] <= d;
      for (int i = 1; i < STAGES; i++) st[i] <= st[i-1];
    end
  end

  assign q = st[STAGES-1];
endmodule

// File: rtl/sdac_shift.sv
module sdac_shift #(
  parameter int FRAME_W = 14
) (
  input  logic               clk,
  input  logic               rst,
  input  logic               s_clk,
  input  logic               s_dat,
  input  logic               s_ld,
  input  logic               s_rstn,
  output logic [FRAME_W-1:0] word,
  output logic               viol
);
  logic clk_q;
  logic rise;
  logic any_edge;

  always_ff @(posedge clk) begin
    if (rst) clk_q <= 1'b0;
    else     clk_q <= s_clk;
  end

  assign rise     = s_clk & ~clk_q;
  assign any_edge = s_clk ^ clk_q;

  // shift register has no reset: undefined until the first frame
  always_ff @(posedge clk) begin
    if (rise) word <= {word[FRAME_W-2:0], s_dat};
  end

  always_ff @(posedge clk) begin
    if (rst)                  viol <= 1'b0;
    else if (!s_rstn)         viol <= 1'b0;
    else if (s_ld && any_edge) viol <= 1'b1;
  end

  AST_SHIFT_HOLD: assert property (@(posedge clk) disable iff (rst)
    !rise |=> $stable(word)); // R5
  AST_TOGGLE_FLAGS: assert property (@(posedge clk) disable iff (rst)
    (s_rstn && s_ld && any_edge) |=> viol); // R8
  AST_FLAG_STICKY: assert property (@(posedge clk) disable iff (rst)
    (viol && s_rstn) |=> viol); // R9
  AST_NO_EDGE_NO_FLAG: assert property (@(posedge clk) disable iff (rst)
    (!viol && !any_edge) |=> !viol); // R7
endmodule

// File: rtl/sdac_bank.sv
module sdac_bank #(
  parameter int DATA_W = 10,
  parameter int ADDR_W = 4,
  parameter int NUM_CH = 6,
  localparam int FRAME_W = ADDR_W + DATA_W
) (
  input  logic                     clk,
  input  logic                     rst,
  input  logic                     s_ld,
  input  logic                     s_rstn,
  input  logic [FRAME_W-1:0]       word,
  output logic [NUM_CH*DATA_W-1:0] ch_out
);
  logic [ADDR_W-1:0] addr;
  logic [DATA_W-1:0] code;
  logic              addr_ok;

  assign addr    = word[FRAME_W-1:DATA_W];
  assign code    = word[DATA_W-1:0];
  assign addr_ok = (addr >= ADDR_W'(1)) && (addr <= ADDR_W'(NUM_CH));

  for (genvar k = 0; k < NUM_CH; k++) begin : g_ch
    logic [DATA_W-1:0] lat;

    // no power-on value: only the clear line or a load defines it
    always_ff @(posedge clk) begin
      if (!s_rstn)                              lat <= '0;
      else if (s_ld && addr == ADDR_W'(k + 1))  lat <= code;
    end

    assign ch_out[k*DATA_W +: DATA_W] = lat;

    AST_LOAD_WRITE: assert property (@(posedge clk) disable iff (rst)
      (s_rstn && s_ld && addr == ADDR_W'(k + 1)) |=> (lat == $past(code))); // R2
  end

  AST_RST_CLEARS: assert property (@(posedge clk) disable iff (rst)
    !s_rstn |=> (ch_out == '0)); // R4
  AST_BAD_ADDR_HOLD: assert property (@(posedge clk) disable iff (rst)
    (s_rstn && s_ld && !addr_ok) |=> $stable(ch_out)); // R3
endmodule

// File: rtl/sdac_front.sv
module sdac_front #(
  parameter int DATA_W = sdac_pkg::DEF_DATA_W,
  parameter int ADDR_W = sdac_pkg::DEF_ADDR_W,
  parameter int NUM_CH = sdac_pkg::DEF_NUM_CH,
  parameter int SYNC_N = sdac_pkg::DEF_SYNC
) (
  input  logic                     clk,
  input  logic                     rst,
  input  logic                     ser_clk,
  input  logic                     ser_dat,
  input  logic                     ser_ld,
  input  logic                     ser_rst_n,
  output logic [NUM_CH*DATA_W-1:0] ch_out,
  output logic                     viol
);
  localparam int FRAME_W = ADDR_W + DATA_W;

  logic [3:0]         sync_q;
  logic [FRAME_W-1:0] word;

  // idle values: clear line high, others low
  sdac_sync #(.WIDTH(4), .STAGES(SYNC_N), .RST_VAL(4'b1000)) u_sync (
    .clk (clk),
    .rst (rst),
    .d   ({ser_rst_n, ser_ld, ser_dat, ser_clk}),
    .q   (sync_q)
  );

  sdac_shift #(.FRAME_W(FRAME_W)) u_shift (
    .clk    (clk),
    .rst    (rst),
    .s_clk  (sync_q[0]),
    .s_dat  (sync_q[1]),
    .s_ld   (sync_q[2]),
    .s_rstn (sync_q[3]),
    .word   (word),
    .viol   (viol)
  );

  sdac_bank #(.DATA_W(DATA_W), .ADDR_W(ADDR_W), .NUM_CH(NUM_CH)) u_bank (
    .clk    (clk),
    .rst    (rst),
    .s_ld   (sync_q[2]),
    .s_rstn (sync_q[3]),
    .word   (word),
    .ch_out (ch_out)
  );
endmodule

// File: tb/sim_sdac_front.sv
`timescale 1ns/1ps
module sim_sdac_front;
  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        ser_clk = 1'b0, ser_dat = 1'b0, ser_ld = 1'b0, ser_rst_n = 1'b1;
  logic [59:0] ch_out;
  logic        viol;

  int n_run = 0, n_fail = 0;
  bit done = 0;
  logic [9:0]  exp_ch [6];
  logic [13:0] mw;     // model of the shifted word
  bit          ld_on;  // model: load currently high

  always #10 clk = ~clk;

  sdac_front u0 (.clk(clk), .rst(rst), .ser_clk(ser_clk), .ser_dat(ser_dat),
                 .ser_ld(ser_ld), .ser_rst_n(ser_rst_n), .ch_out(ch_out), .viol(viol));

  task automatic settle();
    repeat (10) @(negedge clk);
  endtask

  task automatic chk(string tag, logic [31:0] act, logic [31:0] expv);
    n_run++;
    if (act !== expv) begin
      n_fail++;
      $display("FAIL %s: actual %0h expected %0h", tag, act, expv);
    end
  endtask

  task automatic check_all(string tag);
    for (int k = 0; k < 6; k++) chk(tag, 32'(ch_out[k*10 +: 10]), 32'(exp_ch[k]));
  endtask

  task automatic model_shift(logic b);
    mw = {mw[12:0], b};
    if (ld_on && mw[13:10] >= 1 && mw[13:10] <= 6) exp_ch[mw[13:10]-1] = mw[9:0];
  endtask

  task automatic send_frame(logic [3:0] a, logic [9:0] d, bit leave_high);
    logic [13:0] f;
    f = {a, d};
    for (int i = 13; i >= 0; i--) begin
      ser_dat = f[i];
      #60 ser_clk = 1'b1;
      model_shift(f[i]);
      #100;
      if (i != 0 || !leave_high) begin
        ser_clk = 1'b0;
        #60;
      end
    end
    settle();
  endtask

  task automatic do_load();
    ser_ld = 1'b1; ld_on = 1;
    if (mw[13:10] >= 1 && mw[13:10] <= 6) exp_ch[mw[13:10]-1] = mw[9:0];
    #200 ser_ld = 1'b0; ld_on = 0;
    settle();
  endtask

  task automatic do_clear();
    ser_rst_n = 1'b0;
    for (int k = 0; k < 6; k++) exp_ch[k] = '0;
    #200 ser_rst_n = 1'b1;
    settle();
  endtask

  task automatic t_reset();
    repeat (5) @(negedge clk);
    rst = 1'b0;
    settle();
    chk("R9 flag clear after rst", 32'(viol), 0);
    do_clear();
    check_all("R4 clear zeroes channels");
  endtask

  task automatic t_write_all();
    for (int c = 1; c <= 6; c++) begin
      send_frame(4'(c), 10'h2A5 ^ 10'(c * 77), 0);
      do_load();
    end
    check_all("R1 R2 write each channel");
    chk("R7 no flag on clean loads", 32'(viol), 0);
  endtask

  task automatic t_bad_addr();
    send_frame(4'd0, 10'h155, 0); do_load();
    send_frame(4'd7, 10'h0AA, 0); do_load();
    send_frame(4'd15, 10'h3FF, 0); do_load();
    check_all("R3 invalid channel number ignored");
  endtask

  task automatic t_clk_high_load();
    send_frame(4'd4, 10'h2C3, 1);
    do_load();
    ser_clk = 1'b0;
    settle();
    chk("R7 load with serial clock high", 32'(ch_out[30 +: 10]), 32'h2C3);
    chk("R7 no flag with clock high at load", 32'(viol), 0);
  endtask

  task automatic t_reset_keeps();
    send_frame(4'd3, 10'h0F1, 0);
    do_load();
    do_clear();
    check_all("R4 clear after writes");
    do_load();
    check_all("R5 shift word survives clear");
  endtask

  task automatic t_reset_priority();
    ser_rst_n = 1'b0;
    for (int k = 0; k < 6; k++) exp_ch[k] = '0;
    settle();
    ser_ld = 1'b1;
    settle();
    check_all("R6 clear over load");
    ser_ld = 1'b0;
    settle();
    ser_rst_n = 1'b1;
    settle();
  endtask

  task automatic t_passthrough();
    send_frame(4'd1, 10'h1E7, 0);
    ser_ld = 1'b1; ld_on = 1;
    exp_ch[0] = 10'h1E7;
    settle();
    send_frame(4'd2, 10'h39C, 0);
    check_all("R8 pass-through while load high");
    chk("R8 flag set by toggle", 32'(viol), 1);
    ser_ld = 1'b0; ld_on = 0;
    settle();
    send_frame(4'd5, 10'h063, 0);
    do_load();
    check_all("R2 write after violation");
    chk("R9 flag sticky", 32'(viol), 1);
    do_clear();
    chk("R9 flag cleared by clear line", 32'(viol), 0);
    check_all("R4 clear after pass-through");
  endtask

  initial begin
    t_reset();
    t_write_all();
    t_bad_addr();
    t_clk_high_load();
    t_reset_keeps();
    t_reset_priority();
    t_passthrough();
    done = 1;
    $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      n_run++; n_fail++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
      $finish;
    end
  end
endmodule